// File: doc/BRIEF.md
# Single-Channel Burst DMA Engine

This block is one self-contained DMA channel. Software programs a small register file: a source and a destination address, a word count per start, a total count for counted operation, a burst spacing timer with a prescaler, a fill constant and a control word. The channel then moves 32-bit words over a simple request/acknowledge memory port. Each word is a read at the working source address followed by a write of that data to the working destination address. In fill mode the channel skips the read and writes the fill constant.

Words travel in atomic bursts of a power-of-two length. Inside a burst the next request follows the previous acknowledge with no idle cycle. Between two bursts of the same run the channel waits a programmed number of prescaled timer ticks. A run starts in one of three ways. In immediate mode it starts as soon as the channel is enabled. In repeat mode it starts on every selected trigger. In counted mode it starts on every selected trigger and the channel shuts itself off once a programmed total has been moved. A completion interrupt pulse is available.

Top module: `dmx_chan`

## Requirements
- R1: After reset the channel issues no memory request, `irq_o` is low, and the control word reads back with bit 31 (enable/busy) clear.
- R2: Each non-fill word is a read (`mem_we_o`=0) at the working source address, then a write (`mem_we_o`=1) of the returned data at the working destination address. Address register writes (source at index 0, destination at index 1) load the working copies with the two low bits forced to zero. A request holds steady until it is acknowledged.
- R3: Control bits [11:10] set the destination step and bits [14:13] the source step: 0 adds 4, 1 subtracts 4, 2 holds. A source mode of 3 selects fill: no reads are issued and every write carries the fill register (index 5).
- R4: A run is split into bursts of min(2^B, words left), with B in control bits [19:16]. Inside a burst each request follows the previous acknowledge on the next cycle.
- R5: Between two bursts of one run, `mem_req_o` stays low for exactly N·4^P cycles. N is bits [15:0] and P is bits [17:16] of the spacing register (index 4). When that product is zero, no cycle is left between bursts.
- R6: With the immediate bit (control bit 28) set, enabling the channel (writing bit 31 from 0 to 1) moves the word count (index 3) once and then clears bit 31. The total count and the repeat bit have no effect.
- R7: Counted mode (bits 28 and 29 clear) moves min(word count, total left) on each selected trigger. The total comes from index 2 and is captured at enable. Bit 31 clears when the total is exhausted and stays set before that.
- R8: Repeat mode (bit 29 set, bit 28 clear) moves the word count on each selected trigger, and the channel stays enabled.
- R9: Only `trig_i[S]` starts a run, with S in control bits [27:24]. Pulses on other trigger lines cause no memory request.
- R10: A selected trigger that arrives while a run is active is latched and starts another run once the current one ends.
- R11: With the destination reload flag (bit 12) or the source reload flag (bit 15) set, the working address restarts from its programmed value at each triggered run. With the flag clear, it continues from where the previous run stopped.
- R12: With the interrupt enable (bit 30) set, `irq_o` pulses for one cycle after the final write of a run that either disables the channel or runs in repeat mode.
- R13: Writing the control word with bit 31 clear while the channel is idle makes bit 31 read 0, and later triggers start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_widx_i | input | 3 | Register index for the write |
| reg_wdata_i | input | 32 | Register write data |
| reg_ridx_i | input | 3 | Register index for the read |
| reg_rdata_o | output | 32 | Read data for `reg_ridx_i`, combinational |
| trig_i | input | TRIG_N | Start event lines, one-cycle pulses |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Word-aligned memory address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request accepted this cycle |
| mem_rdata_i | input | 32 | Read data, valid with `mem_ack_i` on a read |
| irq_o | output | 1 | Completion interrupt pulse |

## Verification
The assertions assume the following about the environment. `mem_ack_i` rises only while a request is pending, and read data is valid in the acknowledge cycle. Triggers are single-cycle pulses. The control word is not rewritten while a run is in progress, and the word count is never zero. The bench keeps to all of this: it acknowledges every request in the cycle it appears, drives each trigger high for exactly one clock, and reprograms registers only after the expected transfer list has drained and the channel is idle.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

   // address step modes, shared by source and destination generators
   typedef enum logic [1:0] {
      AM_INC  = 2'd0,
      AM_DEC  = 2'd1,
      AM_HOLD = 2'd2,
      AM_NONE = 2'd3
   } amode_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_RD,
      ST_WR,
      ST_GAP
   } seq_st_e;

   // control word, msb first; bit positions are part of the software contract
   typedef struct packed {
      logic       en;        // 31
      logic       irq_en;    // 30
      logic       rep;       // 29
      logic       imm;       // 28
      logic [3:0] evt_sel;   // 27:24
      logic [3:0] rsv_hi;    // 23:20
      logic [3:0] bsize;     // 19:16
      logic       src_rel;   // 15
      amode_e     src_mode;  // 14:13
      logic       dst_rel;   // 12
      amode_e     dst_mode;  // 11:10
      logic [9:0] rsv_lo;    // 9:0
   } ctrl_t;

   localparam logic [2:0] RI_SRC   = 3'd0;
   localparam logic [2:0] RI_DST   = 3'd1;
   localparam logic [2:0] RI_TOTAL = 3'd2;
   localparam logic [2:0] RI_WORDS = 3'd3;
   localparam logic [2:0] RI_GAP   = 3'd4;
   localparam logic [2:0] RI_FILL  = 3'd5;
   localparam logic [2:0] RI_CTRL  = 3'd6;

   localparam int PS_LSB = 16;

endpackage

// File: rtl/dmx_regs.sv
module dmx_regs
   import dmx_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int WCNT_W = 24,
   parameter int TCNT_W = 28,
   parameter int GAP_W  = 16,
   parameter int PS_W   = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              we_i,
   input  logic [2:0]        widx_i,
   input  logic [31:0]       wdata_i,
   input  logic [2:0]        ridx_i,
   output logic [31:0]       rdata_o,
   input  logic              clr_en_i,
   output ctrl_t             ctrl_o,
   output logic [WCNT_W-1:0] words_o,
   output logic [TCNT_W-1:0] total_o,
   output logic [GAP_W-1:0]  gap_o,
   output logic [PS_W-1:0]   ps_o,
   output logic [31:0]       fill_o,
   output logic [ADDR_W-1:0] src_o,
   output logic [ADDR_W-1:0] dst_o,
   output logic              src_ld_o,
   output logic              dst_ld_o,
   output logic              arm_o
);

   ctrl_t             ctrl_q;
   logic [ADDR_W-1:0] src_q, dst_q;
   logic [WCNT_W-1:0] words_q;
   logic [TCNT_W-1:0] total_q;
   logic [GAP_W-1:0]  gap_q;
   logic [PS_W-1:0]   ps_q;
   logic [31:0]       fill_q;
   logic              arm_q;
   logic              ctrl_wr, en_rise;

   assign ctrl_wr = we_i && (widx_i == RI_CTRL);
   assign en_rise = ctrl_wr && wdata_i[31] && !ctrl_q.en;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctrl_q  <= '0;
         src_q   <= '0;
         dst_q   <= '0;
         words_q <= '0;
         total_q <= '0;
         gap_q   <= '0;
         ps_q    <= '0;
         fill_q  <= '0;
         arm_q   <= 1'b0;
      end else begin
         arm_q <= en_rise;
         if (clr_en_i) ctrl_q.en <= 1'b0;
         if (we_i) begin
            unique case (widx_i)
               RI_SRC:   src_q   <= wdata_i[ADDR_W-1:0];
               RI_DST:   dst_q   <= wdata_i[ADDR_W-1:0];
               RI_TOTAL: total_q <= wdata_i[TCNT_W-1:0];
               RI_WORDS: words_q <= wdata_i[WCNT_W-1:0];
               RI_GAP: begin
                  gap_q <= wdata_i[GAP_W-1:0];
                  ps_q  <= wdata_i[PS_LSB +: PS_W];
               end
               RI_FILL:  fill_q  <= wdata_i;
               RI_CTRL:  ctrl_q  <= ctrl_t'(wdata_i);
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      rdata_o = '0;
      unique case (ridx_i)
         RI_SRC:   rdata_o = 32'(src_q);
         RI_DST:   rdata_o = 32'(dst_q);
         RI_TOTAL: rdata_o = 32'(total_q);
         RI_WORDS: rdata_o = 32'(words_q);
         RI_GAP:   rdata_o = 32'(gap_q) | (32'(ps_q) << PS_LSB);
         RI_FILL:  rdata_o = fill_q;
         RI_CTRL:  rdata_o = 32'(ctrl_q);
         default:  rdata_o = '0;
      endcase
   end

   assign ctrl_o   = ctrl_q;
   assign words_o  = words_q;
   assign total_o  = total_q;
   assign gap_o    = gap_q;
   assign ps_o     = ps_q;
   assign fill_o   = fill_q;
   assign src_o    = src_q;
   assign dst_o    = dst_q;
   assign src_ld_o = we_i && (widx_i == RI_SRC);
   assign dst_ld_o = we_i && (widx_i == RI_DST);
   assign arm_o    = arm_q;

   // R6/R7: arming follows exactly one enabling write
   p_arm_once_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      arm_q |=> !arm_q);

endmodule

// File: rtl/dmx_agen.sv
module dmx_agen
   import dmx_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              ld_i,
   input  logic [ADDR_W-1:0] ld_val_i,
   input  logic              reload_i,
   input  logic [ADDR_W-1:0] reload_val_i,
   input  logic              step_i,
   input  amode_e            mode_i,
   output logic [ADDR_W-1:0] addr_o
);

   localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(4);

   logic [ADDR_W-1:0] addr_q, addr_d;

   always_comb begin
      addr_d = addr_q;
      if (ld_i) begin
         addr_d = ld_val_i;
      end else if (reload_i) begin
         addr_d = reload_val_i;
      end else if (step_i) begin
         unique case (mode_i)
            AM_INC:  addr_d = addr_q + WORD_BYTES;
            AM_DEC:  addr_d = addr_q - WORD_BYTES;
            default: addr_d = addr_q;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) addr_q <= '0;
      else         addr_q <= {addr_d[ADDR_W-1:2], 2'b00};
   end

   assign addr_o = addr_q;

   // R3: an incrementing step advances by one word
   p_inc_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_i && !ld_i && !reload_i && mode_i == AM_INC)
      |=> addr_q == $past(addr_q) + WORD_BYTES);

   // R3: a held address does not move on a step
   p_hold_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_i && !ld_i && !reload_i && mode_i == AM_HOLD) |=> $stable(addr_q));

endmodule

// File: rtl/dmx_pacer.sv
module dmx_pacer #(
   parameter int GAP_W = 16,
   parameter int PS_W  = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic [GAP_W-1:0] interval_i,
   input  logic [PS_W-1:0]  ps_i,
   output logic             zero_o,
   output logic             expire_o
);

   // each prescale step divides the tick by four: two extra count bits per step
   localparam int MAX_SH = (PS_W == 0) ? 0 : 2 * ((1 << PS_W) - 1);
   localparam int CNT_W  = GAP_W + MAX_SH;

   logic [CNT_W-1:0] load_val, cnt_q;

   generate
      if (PS_W == 0) begin : g_noscale
         assign load_val = CNT_W'(interval_i);
      end else begin : g_scale
         assign load_val = CNT_W'(interval_i) << {ps_i, 1'b0};
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               cnt_q <= '0;
      else if (start_i)          cnt_q <= load_val;
      else if (cnt_q != '0)      cnt_q <= cnt_q - CNT_W'(1);
   end

   assign zero_o   = (load_val == '0);
   assign expire_o = (cnt_q == CNT_W'(1));

   // R5: the spacing counter only counts down by one per cycle
   p_count_down_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q != '0 && !start_i) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

endmodule

// File: rtl/dmx_seq.sv
module dmx_seq
   import dmx_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int WCNT_W = 24,
   parameter int TCNT_W = 28,
   parameter int TRIG_N = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  ctrl_t             ctrl_i,
   input  logic [WCNT_W-1:0] words_i,
   input  logic [TCNT_W-1:0] total_i,
   input  logic [31:0]       fill_i,
   input  logic              arm_i,
   input  logic [TRIG_N-1:0] trig_i,
   input  logic [ADDR_W-1:0] src_addr_i,
   input  logic [ADDR_W-1:0] dst_addr_i,
   input  logic              pace_zero_i,
   input  logic              pace_expire_i,
   output logic              pace_start_o,
   output logic              src_step_o,
   output logic              dst_step_o,
   output logic              src_reload_o,
   output logic              dst_reload_o,
   output logic              clr_en_o,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [31:0]       mem_wdata_o,
   input  logic              mem_ack_i,
   input  logic [31:0]       mem_rdata_i,
   output logic              irq_o
);

   seq_st_e           state_q;
   logic [WCNT_W-1:0] run_left_q, beat_left_q;
   logic [TCNT_W-1:0] total_left_q;
   logic [31:0]       data_q;
   logic              pend_q, irq_q;

   logic [15:0] trig_pad;
   logic        evt, start, fill, counted, wr_done, last_word, last_beat, stop_now;
   logic [31:0] blen, words32, total32, run_len, first_len, next_len, gap_len;
   seq_st_e     beat_st;

   assign trig_pad  = 16'(trig_i);
   assign evt       = ctrl_i.en && !ctrl_i.imm && trig_pad[ctrl_i.evt_sel];
   assign start     = (state_q == ST_IDLE) && ctrl_i.en && (pend_q || evt);
   assign fill      = (ctrl_i.src_mode == AM_NONE);
   assign counted   = !ctrl_i.imm && !ctrl_i.rep;
   assign beat_st   = fill ? ST_WR : ST_RD;
   assign wr_done   = (state_q == ST_WR) && mem_ack_i;
   assign last_word = (run_left_q == WCNT_W'(1));
   assign last_beat = (beat_left_q == WCNT_W'(1));
   assign stop_now  = ctrl_i.imm || (counted && total_left_q == TCNT_W'(1));

   always_comb begin
      blen      = 32'd1 << ctrl_i.bsize;
      words32   = 32'(words_i);
      total32   = 32'(total_left_q);
      run_len   = (counted && total32 < words32) ? total32 : words32;
      first_len = (blen < run_len) ? blen : run_len;
      next_len  = 32'(run_left_q) - 32'd1;
      next_len  = (blen < next_len) ? blen : next_len;
      gap_len   = (blen < 32'(run_left_q)) ? blen : 32'(run_left_q);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q      <= ST_IDLE;
         run_left_q   <= '0;
         beat_left_q  <= '0;
         total_left_q <= '0;
         data_q       <= '0;
         pend_q       <= 1'b0;
         irq_q        <= 1'b0;
      end else begin
         irq_q <= wr_done && last_word && ctrl_i.irq_en && (stop_now || ctrl_i.rep);

         if (arm_i)             pend_q <= ctrl_i.imm;
         else if (!ctrl_i.en)   pend_q <= 1'b0;
         else if (start)        pend_q <= pend_q && evt;
         else if (evt)          pend_q <= 1'b1;

         if (arm_i) total_left_q <= total_i;
         else if (wr_done && counted) total_left_q <= total_left_q - TCNT_W'(1);

         unique case (state_q)
            ST_IDLE: begin
               if (start && run_len != 32'd0) begin
                  run_left_q  <= WCNT_W'(run_len);
                  beat_left_q <= WCNT_W'(first_len);
                  state_q     <= beat_st;
               end
            end
            ST_RD: begin
               if (mem_ack_i) begin
                  data_q  <= mem_rdata_i;
                  state_q <= ST_WR;
               end
            end
            ST_WR: begin
               if (mem_ack_i) begin
                  run_left_q  <= run_left_q - WCNT_W'(1);
                  beat_left_q <= beat_left_q - WCNT_W'(1);
                  if (last_word) begin
                     state_q <= ST_IDLE;
                  end else if (last_beat) begin
                     if (!ctrl_i.en) begin
                        state_q <= ST_IDLE;
                     end else if (pace_zero_i) begin
                        beat_left_q <= WCNT_W'(next_len);
                        state_q     <= beat_st;
                     end else begin
                        state_q <= ST_GAP;
                     end
                  end else begin
                     state_q <= beat_st;
                  end
               end
            end
            ST_GAP: begin
               if (!ctrl_i.en) begin
                  state_q <= ST_IDLE;
               end else if (pace_expire_i) begin
                  beat_left_q <= WCNT_W'(gap_len);
                  state_q     <= beat_st;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign pace_start_o = wr_done && last_beat && !last_word && ctrl_i.en;
   assign src_step_o   = wr_done && !fill;
   assign dst_step_o   = wr_done;
   assign src_reload_o = start && !ctrl_i.imm && ctrl_i.src_rel;
   assign dst_reload_o = start && !ctrl_i.imm && ctrl_i.dst_rel;
   assign clr_en_o     = wr_done && last_word && stop_now;
   assign mem_req_o    = (state_q == ST_RD) || (state_q == ST_WR);
   assign mem_we_o     = (state_q == ST_WR);
   assign mem_addr_o   = (state_q == ST_WR) ? dst_addr_i : src_addr_i;
   assign mem_wdata_o  = fill ? fill_i : data_q;
   assign irq_o        = irq_q;

   // R2: an unacknowledged request is held unchanged
   p_hold_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

   // R2: every bus address is word aligned
   p_aligned_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

   // R3: fill mode never reads
   p_fill_no_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_req_o && fill) |-> mem_we_o);

   // R4: a burst never outlasts its run
   p_beat_in_run_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q != ST_IDLE) |-> (beat_left_q <= run_left_q));

   // R7: the remaining total never grows during a run
   p_total_down_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q != ST_IDLE && !arm_i) |=> (total_left_q <= $past(total_left_q)));

   // R12: the interrupt is a single-cycle pulse
   p_irq_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |=> !irq_o);

endmodule

// File: rtl/dmx_chan.sv
module dmx_chan
   import dmx_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int WCNT_W = 24,
   parameter int TCNT_W = 28,
   parameter int GAP_W  = 16,
   parameter int PS_W   = 2,
   parameter int TRIG_N = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              reg_we_i,
   input  logic [2:0]        reg_widx_i,
   input  logic [31:0]       reg_wdata_i,
   input  logic [2:0]        reg_ridx_i,
   output logic [31:0]       reg_rdata_o,
   input  logic [TRIG_N-1:0] trig_i,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [31:0]       mem_wdata_o,
   input  logic              mem_ack_i,
   input  logic [31:0]       mem_rdata_i,
   output logic              irq_o
);

   localparam int NGEN = 2;   // 0: source, 1: destination

   generate
      if (ADDR_W < 3 || ADDR_W > 32) begin : g_bad_addr
         $error("dmx_chan: ADDR_W must lie in 3..32");
      end
      if (WCNT_W < 1 || WCNT_W > 31 || TCNT_W < 1 || TCNT_W > 32) begin : g_bad_cnt
         $error("dmx_chan: count widths out of range");
      end
      if (GAP_W < 1 || GAP_W > PS_LSB || PS_W > 2) begin : g_bad_gap
         $error("dmx_chan: spacing fields do not fit the register");
      end
      if (TRIG_N < 1 || TRIG_N > 16) begin : g_bad_trig
         $error("dmx_chan: TRIG_N must lie in 1..16");
      end
   endgenerate

   ctrl_t             ctrl;
   logic [WCNT_W-1:0] words;
   logic [TCNT_W-1:0] total;
   logic [GAP_W-1:0]  gap;
   logic [PS_W-1:0]   ps;
   logic [31:0]       fill;
   logic              clr_en, arm;
   logic              pace_start, pace_zero, pace_expire;

   logic [ADDR_W-1:0] prog_addr [NGEN];
   logic [ADDR_W-1:0] work_addr [NGEN];
   logic              ld       [NGEN];
   logic              reload   [NGEN];
   logic              step     [NGEN];
   amode_e            mode     [NGEN];

   assign mode[0] = ctrl.src_mode;
   assign mode[1] = ctrl.dst_mode;

   dmx_regs #(
      .ADDR_W(ADDR_W), .WCNT_W(WCNT_W), .TCNT_W(TCNT_W), .GAP_W(GAP_W), .PS_W(PS_W)
   ) u_regs (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (reg_we_i),
      .widx_i   (reg_widx_i),
      .wdata_i  (reg_wdata_i),
      .ridx_i   (reg_ridx_i),
      .rdata_o  (reg_rdata_o),
      .clr_en_i (clr_en),
      .ctrl_o   (ctrl),
      .words_o  (words),
      .total_o  (total),
      .gap_o    (gap),
      .ps_o     (ps),
      .fill_o   (fill),
      .src_o    (prog_addr[0]),
      .dst_o    (prog_addr[1]),
      .src_ld_o (ld[0]),
      .dst_ld_o (ld[1]),
      .arm_o    (arm)
   );

   for (genvar g = 0; g < NGEN; g++) begin : g_agen
      dmx_agen #(.ADDR_W(ADDR_W)) u_agen (
         .clk_i        (clk_i),
         .rst_ni       (rst_ni),
         .ld_i         (ld[g]),
         .ld_val_i     (reg_wdata_i[ADDR_W-1:0]),
         .reload_i     (reload[g]),
         .reload_val_i (prog_addr[g]),
         .step_i       (step[g]),
         .mode_i       (mode[g]),
         .addr_o       (work_addr[g])
      );
   end

   dmx_pacer #(.GAP_W(GAP_W), .PS_W(PS_W)) u_pacer (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_i    (pace_start),
      .interval_i (gap),
      .ps_i       (ps),
      .zero_o     (pace_zero),
      .expire_o   (pace_expire)
   );

   dmx_seq #(
      .ADDR_W(ADDR_W), .WCNT_W(WCNT_W), .TCNT_W(TCNT_W), .TRIG_N(TRIG_N)
   ) u_seq (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .ctrl_i        (ctrl),
      .words_i       (words),
      .total_i       (total),
      .fill_i        (fill),
      .arm_i         (arm),
      .trig_i        (trig_i),
      .src_addr_i    (work_addr[0]),
      .dst_addr_i    (work_addr[1]),
      .pace_zero_i   (pace_zero),
      .pace_expire_i (pace_expire),
      .pace_start_o  (pace_start),
      .src_step_o    (step[0]),
      .dst_step_o    (step[1]),
      .src_reload_o  (reload[0]),
      .dst_reload_o  (reload[1]),
      .clr_en_o      (clr_en),
      .mem_req_o     (mem_req_o),
      .mem_we_o      (mem_we_o),
      .mem_addr_o    (mem_addr_o),
      .mem_wdata_o   (mem_wdata_o),
      .mem_ack_i     (mem_ack_i),
      .mem_rdata_i   (mem_rdata_i),
      .irq_o         (irq_o)
   );

endmodule

// File: tb/dmx_chan_tb.sv
module dmx_chan_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int TN = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_widx = '0;
   logic [31:0] reg_wdata = '0;
   logic [2:0]  reg_ridx = '0;
   logic [31:0] reg_rdata;
   logic [TN-1:0] trig = '0;
   logic        mem_req, mem_we, mem_ack, irq;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;

   int checks = 0;
   int failures = 0;
   int idle_run = 0;
   int irq_cnt = 0;
   int req_cnt = 0;
   bit done = 1'b0;

   logic [31:0] q_addr [$];
   bit          q_we   [$];
   logic [31:0] q_data [$];
   int          q_gap  [$];
   string       q_tag  [$];

   logic [31:0] sw, dw;

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [31:0] memfn(logic [31:0] a);
      return {a[15:0], ~a[15:0]};
   endfunction

   assign mem_ack   = mem_req;
   assign mem_rdata = memfn(mem_addr);

   dmx_chan dut_i (
      .clk_i(clk), .rst_ni(rst_n),
      .reg_we_i(reg_we), .reg_widx_i(reg_widx), .reg_wdata_i(reg_wdata),
      .reg_ridx_i(reg_ridx), .reg_rdata_o(reg_rdata),
      .trig_i(trig),
      .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
      .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
      .irq_o(irq)
   );

   task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mk_ctrl(bit en, bit irqe, bit rep, bit imm, int sel,
                                           int bsz, bit srel, int sm, bit drel, int dm);
      return {en, irqe, rep, imm, 4'(sel), 4'b0, 4'(bsz), srel, 2'(sm), drel, 2'(dm), 10'b0};
   endfunction

   function automatic logic [31:0] step_addr(logic [31:0] a, int m);
      if (m == 0) return a + 32'd4;
      if (m == 1) return a - 32'd4;
      return a;
   endfunction

   // reference model: expected bus transactions of one run, with required idle gaps
   task automatic push_run(int n, int burst, int gap, int sm, int dm,
                           logic [31:0] fillv, string tag);
      for (int i = 0; i < n; i++) begin
         int g;
         g = (i == 0) ? -1 : ((i % burst) == 0 ? gap : 0);
         if (sm != 3) begin
            q_addr.push_back(sw); q_we.push_back(1'b0);
            q_data.push_back(32'h0); q_gap.push_back(g); q_tag.push_back(tag);
            g = 0;
         end
         q_addr.push_back(dw); q_we.push_back(1'b1);
         q_data.push_back(sm == 3 ? fillv : memfn(sw));
         q_gap.push_back(g); q_tag.push_back(tag);
         if (sm != 3) sw = step_addr(sw, sm);
         dw = step_addr(dw, dm);
      end
   endtask

   // per-clock comparison of the bus against the expected list
   always @(negedge clk) begin
      if (rst_n) begin
         if (irq) irq_cnt++;
         if (mem_req) begin
            req_cnt++;
            if (q_addr.size() == 0) begin
               chk(1'b0, "R9", "unexpected request addr", mem_addr, 32'h0);
            end else begin
               chk(mem_addr == q_addr[0], q_tag[0], "R2 addr", mem_addr, q_addr[0]);
               chk(mem_we == q_we[0], q_tag[0], "R2 dir", 32'(mem_we), 32'(q_we[0]));
               if (q_we[0])
                  chk(mem_wdata == q_data[0], q_tag[0], "R2/R3 wdata", mem_wdata, q_data[0]);
               if (q_gap[0] >= 0)
                  chk(idle_run == q_gap[0], q_tag[0], "R4/R5 idle cycles before request",
                      32'(idle_run), 32'(q_gap[0]));
               void'(q_addr.pop_front()); void'(q_we.pop_front());
               void'(q_data.pop_front()); void'(q_gap.pop_front()); void'(q_tag.pop_front());
            end
            idle_run = 0;
         end else begin
            idle_run++;
         end
      end
   end

   task automatic wreg(logic [2:0] idx, logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_widx = idx; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rreg(logic [2:0] idx, output logic [31:0] v);
      @(negedge clk);
      reg_ridx = idx;
      #1 v = reg_rdata;
   endtask

   task automatic pulse(int k);
      @(negedge clk);
      trig = TN'(1) << k;
      @(negedge clk);
      trig = '0;
   endtask

   task automatic drain(string tag);
      int guard = 0;
      while (q_addr.size() != 0 && guard < 5000) begin
         @(negedge clk);
         guard++;
      end
      repeat (4) @(negedge clk);
      chk(q_addr.size() == 0, tag, "expected transfers left over", 32'(q_addr.size()), 32'h0);
   endtask

   initial begin
      logic [31:0] v;
      int irq0, req0;

      repeat (3) @(negedge clk);
      // R1: reset state
      chk(mem_req == 1'b0, "R1", "mem_req in reset", 32'(mem_req), 32'h0);
      chk(irq == 1'b0, "R1", "irq in reset", 32'(irq), 32'h0);
      rst_n = 1'b1;
      rreg(3'd6, v);
      chk(v[31] == 1'b0, "R1", "busy after reset", 32'(v[31]), 32'h0);
      repeat (3) @(negedge clk);
      chk(req_cnt == 0, "R1", "requests after reset", 32'(req_cnt), 32'h0);

      // R6 + R4 + R5 + R2: immediate, inc/inc, 6 words, bursts of 4, gap 3*4
      wreg(3'd0, 32'h0000_1000);
      wreg(3'd1, 32'h0000_2003);
      wreg(3'd2, 32'd1);
      wreg(3'd3, 32'd6);
      wreg(3'd4, (32'd1 << 16) | 32'd3);
      sw = 32'h1000; dw = 32'h2000;
      push_run(6, 4, 12, 0, 0, 32'h0, "R6");
      irq0 = irq_cnt;
      wreg(3'd6, mk_ctrl(1, 1, 1, 1, 0, 2, 0, 0, 0, 0));
      drain("R6");
      rreg(3'd6, v);
      chk(v[31] == 1'b0, "R6", "busy after immediate run", 32'(v[31]), 32'h0);
      chk(irq_cnt == irq0 + 1, "R12", "irq pulses after immediate run",
          32'(irq_cnt - irq0), 32'd1);

      // R3: fill mode, destination decrement, bursts of 1, gap 2, irq disabled
      wreg(3'd1, 32'h0000_3000);
      wreg(3'd3, 32'd5);
      wreg(3'd4, 32'd2);
      wreg(3'd5, 32'hCAFE_F00D);
      dw = 32'h3000;
      push_run(5, 1, 2, 3, 1, 32'hCAFE_F00D, "R3");
      irq0 = irq_cnt;
      wreg(3'd6, mk_ctrl(1, 0, 0, 1, 0, 0, 0, 3, 0, 1));
      drain("R3");
      chk(irq_cnt == irq0, "R12", "irq with interrupt disabled", 32'(irq_cnt - irq0), 32'h0);

      // R3 + R5: source decrement, destination fixed, prescale 64, bursts of 2
      wreg(3'd0, 32'h0000_4010);
      wreg(3'd1, 32'h0000_5000);
      wreg(3'd3, 32'd3);
      wreg(3'd4, (32'd3 << 16) | 32'd1);
      sw = 32'h4010; dw = 32'h5000;
      push_run(3, 2, 64, 1, 2, 32'h0, "R5");
      wreg(3'd6, mk_ctrl(1, 0, 0, 1, 0, 1, 0, 1, 0, 2));
      drain("R5");

      // R7 + R9 + R11: counted mode, total 5, 3 per trigger, dst reload, src continues
      wreg(3'd0, 32'h0000_6000);
      wreg(3'd1, 32'h0000_7000);
      wreg(3'd2, 32'd5);
      wreg(3'd3, 32'd3);
      wreg(3'd4, 32'd0);
      sw = 32'h6000; dw = 32'h7000;
      irq0 = irq_cnt;
      wreg(3'd6, mk_ctrl(1, 1, 0, 0, 5, 3, 0, 0, 1, 0));
      req0 = req_cnt;
      pulse(2);
      repeat (10) @(negedge clk);
      chk(req_cnt == req0, "R9", "requests after unselected trigger", 32'(req_cnt - req0), 32'h0);
      push_run(3, 8, 0, 0, 0, 32'h0, "R7");
      pulse(5);
      drain("R7");
      rreg(3'd6, v);
      chk(v[31] == 1'b1, "R7", "busy before total exhausted", 32'(v[31]), 32'h1);
      chk(irq_cnt == irq0, "R12", "irq before total exhausted", 32'(irq_cnt - irq0), 32'h0);
      dw = 32'h7000;   // R11: destination restarts, source carries on
      push_run(2, 8, 0, 0, 0, 32'h0, "R11");
      pulse(5);
      drain("R7");
      rreg(3'd6, v);
      chk(v[31] == 1'b0, "R7", "busy after total exhausted", 32'(v[31]), 32'h0);
      chk(irq_cnt == irq0 + 1, "R12", "irq at counted completion", 32'(irq_cnt - irq0), 32'h1);

      // R8 + R10 + R11: repeat mode, a trigger during a run is served afterwards
      wreg(3'd0, 32'h0000_8000);
      wreg(3'd1, 32'h0000_9000);
      wreg(3'd3, 32'd4);
      wreg(3'd4, 32'd5);
      sw = 32'h8000; dw = 32'h9000;
      irq0 = irq_cnt;
      wreg(3'd6, mk_ctrl(1, 1, 1, 0, 0, 0, 0, 0, 0, 0));
      push_run(4, 1, 5, 0, 0, 32'h0, "R8");
      push_run(4, 1, 5, 0, 0, 32'h0, "R10");
      pulse(0);
      repeat (4) @(negedge clk);
      pulse(0);
      drain("R10");
      chk(irq_cnt == irq0 + 2, "R12", "irq per repeat run", 32'(irq_cnt - irq0), 32'd2);
      rreg(3'd6, v);
      chk(v[31] == 1'b1, "R8", "busy stays set in repeat mode", 32'(v[31]), 32'h1);

      // R13: software disable, later triggers ignored
      wreg(3'd6, mk_ctrl(0, 1, 1, 0, 0, 0, 0, 0, 0, 0));
      rreg(3'd6, v);
      chk(v[31] == 1'b0, "R13", "busy after disable", 32'(v[31]), 32'h0);
      req0 = req_cnt;
      irq0 = irq_cnt;
      pulse(0);
      repeat (10) @(negedge clk);
      chk(req_cnt == req0, "R13", "requests after disable", 32'(req_cnt - req0), 32'h0);
      chk(irq_cnt == irq0, "R13", "irq after disable", 32'(irq_cnt - irq0), 32'h0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule